// File: doc/BRIEF.md
# ADC Digital Output Stage

This block is the digital back end of a pipelined analog-to-digital converter. On every rising edge of the encode clock it takes one corrected 14-bit offset-binary result together with two range flags, one for a result above full scale and one for a result below it. An out-of-range result is replaced by the matching end-of-scale code. The result and a combined overflow flag then travel through a fixed five-cycle latency line, so that the word and its flag reach the output bus together.

At the output a static format pin selects offset binary or two's complement. Two's complement is formed by inverting the most significant bit. Next to the data the block drives a data-valid clock, which is the inverted encode clock. Its falling edge coincides with the data update, so a receiver latches on its rising edge. After a synchronous reset this clock stays low until the latency line holds a real sample. An active-low output enable releases the data bus, the overflow flag and the data-valid clock to high impedance. The enable is meant for long idle periods, not for toggling on every cycle.

Top module: `adc_out_stage`

## Requirements
- R1: A result presented at `code_in` before encode rising edge N is driven on `dat_out` from just after rising edge N+5 until rising edge N+6.
- R2: With `fmt_sel` = 1 the word is driven unchanged (offset binary). With `fmt_sel` = 0, bit 13 is inverted and bits 12..0 are unchanged (two's complement). `dat_out[0]` is the LSB.
- R3: When `over_hi` = 1 the stored code is 14'h3FFF. When `over_lo` = 1 and `over_hi` = 0 it is 14'h0000. Both substitutions happen before format selection, and `over_hi` takes priority.
- R4: `ovf_out` is 1 exactly when the word on `dat_out` came from a sample with `over_hi` or `over_lo` set. It follows the same five-cycle latency as the data.
- R5: While `oe_n` = 1, `dat_out`, `ovf_out` and `dvalid_clk` are all high impedance. While `oe_n` = 0 all three are driven.
- R6: Once the line is filled, `dvalid_clk` is low while `enc_clk` is high and high while `enc_clk` is low. It therefore falls at the encode rising edge where `dat_out` changes.
- R7: A synchronous active-low reset clears the latency line. After reset, `dvalid_clk` stays low, `ovf_out` stays 0 and `dat_out` shows the formatted zero code until six rising edges have passed with `rst_n` = 1. Once raised, the valid state holds until the next reset.
- R8: `oe_n` has no effect on the latency line. After the bus is enabled again, the driven words are exactly those R1 predicts, as if the bus had never been released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| enc_clk | input | 1 | Encode clock; results are taken on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| code_in | input | 14 | Corrected offset-binary conversion result |
| over_hi | input | 1 | Result is above full scale |
| over_lo | input | 1 | Result is below zero scale |
| fmt_sel | input | 1 | 1 = offset binary, 0 = two's complement (bit 13 inverted) |
| oe_n | input | 1 | Active-low output enable |
| dat_out | output | 14 | Tri-state output data bus |
| ovf_out | output | 1 | Tri-state over/under-range flag, aligned with dat_out |
| dvalid_clk | output | 1 | Tri-state data-valid clock; latch data on its rising edge |

## Verification
Range substitution and format conversion can act on the same word. The bench provokes this by raising `over_hi`, `over_lo` or both while `fmt_sel` is low. The end-of-scale code must then appear five cycles later with bit 13 inverted, for example 14'h1FFF for an over-range result. Line fill and output release can also fall in the same cycle: the bench releases and re-enables the bus, and resets in the middle of a run. It then judges, from its own model of the five-stage line, whether the re-enabled bus carries the aligned word and whether `dvalid_clk` is held low or toggling.

// File: rtl/adc_out_pkg.sv
// Package: shared encodings and default sizes for the ADC digital output stage.
// Assumes: consumers take widths from their own parameters; these are defaults only.
package adc_out_pkg;

    // Output code format selected by the format pin.
    typedef enum logic {
        FMT_TWOS   = 1'b0,
        FMT_OFFSET = 1'b1
    } fmt_e;

    localparam int DEF_WIDTH   = 14;
    localparam int DEF_LATENCY = 5;

endpackage

// File: rtl/adc_range_clamp.sv
// Module: adc_range_clamp
// Replaces an out-of-range result by the matching end-of-scale code and packs
// the combined range flag above the code, giving one word for the latency line.
// Assumes: the code is offset binary; the over-scale flag wins if both are set.
module adc_range_clamp #(
    parameter int WIDTH = 14
) (
    input  logic [WIDTH-1:0] code_i,
    input  logic             hi_i,
    input  logic             lo_i,
    output logic [WIDTH:0]   word_o
);

    // Select the stored code and set the flag bit.
    always_comb begin
        if (hi_i) begin
            word_o = {1'b1, {WIDTH{1'b1}}};
        end else if (lo_i) begin
            word_o = {1'b1, {WIDTH{1'b0}}};
        end else begin
            word_o = {1'b0, code_i};
        end
    end

endmodule

// File: rtl/adc_lat_pipe.sv
// Module: adc_lat_pipe
// A capture register followed by LAT delay registers. The word present at edge N
// reaches the last stage at edge N+LAT.
// Assumes: synchronous active-low reset clears every stage to zero.
module adc_lat_pipe #(
    parameter int DW  = 15,
    parameter int LAT = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] cap_o,
    output logic [DW-1:0] dout
);

    logic [DW-1:0] stg [0:LAT];

    // Capture stage: take the incoming word on each encode edge.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= din;
    end

    genvar g;
    generate
        for (g = 1; g <= LAT; g++) begin : g_stage
            // Delay stage g: move the word one cycle along.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= stg[g-1];
            end
        end
    endgenerate

    assign cap_o = stg[0];
    assign dout  = stg[LAT];

endmodule

// File: rtl/adc_fill_tracker.sv
// Module: adc_fill_tracker
// Counts encode edges since reset, up to LAT+1, and raises full_o once the last
// pipeline stage holds a sample taken after reset.
// Assumes: the count saturates, so full_o stays high until the next reset.
module adc_fill_tracker #(
    parameter int LAT = 5
) (
    input  logic clk,
    input  logic rst_n,
    output logic full_o
);

    localparam int          CW   = $clog2(LAT + 2);
    localparam logic [CW-1:0] FILL = CW'(LAT + 1);

    logic [CW-1:0] cnt;

    // Saturating count of edges since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (cnt != FILL) cnt <= cnt + 1'b1;
    end

    assign full_o = (cnt == FILL);

endmodule

// File: rtl/adc_bus_drive.sv
// Module: adc_bus_drive
// Applies the output format, forms the data-valid clock and drives the
// tri-state outputs.
// Assumes: full_i changes only at encode rising edges, when ~clk is already
// low, so gating the clock with it cannot produce a glitch.
module adc_bus_drive
    import adc_out_pkg::*;
#(
    parameter int WIDTH = 14
) (
    input  logic             clk,
    input  logic             full_i,
    input  logic             fmt_i,
    input  logic             oe_n_i,
    input  logic [WIDTH:0]   word_i,
    output logic [WIDTH-1:0] fmt_word_o,
    output logic [WIDTH-1:0] dat_o,
    output logic             ovf_o,
    output logic             dck_o
);

    logic msb_flip;
    logic dck_int;

    // Invert the MSB when two's complement is selected.
    always_comb begin
        msb_flip   = (fmt_e'(fmt_i) == FMT_TWOS);
        fmt_word_o = word_i[WIDTH-1:0] ^ {msb_flip, {(WIDTH-1){1'b0}}};
    end

    // Data-valid clock: inverted encode clock, held low until the line is full.
    assign dck_int = full_i & ~clk;

    // Tri-state drivers, released when the enable is high.
    assign dat_o = oe_n_i ? {WIDTH{1'bz}} : fmt_word_o;
    assign ovf_o = oe_n_i ? 1'bz : word_i[WIDTH];
    assign dck_o = oe_n_i ? 1'bz : dck_int;

endmodule

// File: rtl/adc_out_stage.sv
// Module: adc_out_stage (top)
// Digital output stage of a pipelined converter: range substitution, fixed
// latency line, format select, data-valid clock and tri-state outputs.
// Assumes: one result per encode rising edge; fmt_sel is static in normal use.
module adc_out_stage
    import adc_out_pkg::*;
#(
    parameter int WIDTH   = DEF_WIDTH,
    parameter int LATENCY = DEF_LATENCY
) (
    input  logic             enc_clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] code_in,
    input  logic             over_hi,
    input  logic             over_lo,
    input  logic             fmt_sel,
    input  logic             oe_n,
    output logic [WIDTH-1:0] dat_out,
    output logic             ovf_out,
    output logic             dvalid_clk
);

    localparam int DW = WIDTH + 1;

    logic [DW-1:0]    in_word;
    logic [DW-1:0]    cap_word;
    logic [DW-1:0]    out_word;
    logic [WIDTH-1:0] fmt_word;
    logic             full;

    adc_range_clamp #(.WIDTH(WIDTH)) u_clamp (
        .code_i (code_in),
        .hi_i   (over_hi),
        .lo_i   (over_lo),
        .word_o (in_word)
    );

    adc_lat_pipe #(.DW(DW), .LAT(LATENCY)) u_pipe (
        .clk   (enc_clk),
        .rst_n (rst_n),
        .din   (in_word),
        .cap_o (cap_word),
        .dout  (out_word)
    );

    adc_fill_tracker #(.LAT(LATENCY)) u_fill (
        .clk    (enc_clk),
        .rst_n  (rst_n),
        .full_o (full)
    );

    adc_bus_drive #(.WIDTH(WIDTH)) u_drive (
        .clk        (enc_clk),
        .full_i     (full),
        .fmt_i      (fmt_sel),
        .oe_n_i     (oe_n),
        .word_i     (out_word),
        .fmt_word_o (fmt_word),
        .dat_o      (dat_out),
        .ovf_o      (ovf_out),
        .dck_o      (dvalid_clk)
    );

endmodule

// File: rtl/adc_out_stage_chk.sv
// Module: adc_out_stage_chk
// Property checker bound to adc_out_stage; it observes only and drives nothing.
// Assumes: all properties are sampled on the encode rising edge, outside reset.
module adc_out_stage_chk #(
    parameter int WIDTH = 14
) (
    input logic             enc_clk,
    input logic             rst_n,
    input logic             over_hi,
    input logic             over_lo,
    input logic             fmt_sel,
    input logic [WIDTH:0]   cap_word,
    input logic [WIDTH:0]   out_word,
    input logic [WIDTH-1:0] fmt_word,
    input logic             full
);

    AST_CLAMP_HI: assert property (@(posedge enc_clk) disable iff (!rst_n)
        over_hi |=> (cap_word == {1'b1, {WIDTH{1'b1}}})); // R3

    AST_CLAMP_LO: assert property (@(posedge enc_clk) disable iff (!rst_n)
        (over_lo && !over_hi) |=> (cap_word == {1'b1, {WIDTH{1'b0}}})); // R3

    AST_FLAG_WORD: assert property (@(posedge enc_clk) disable iff (!rst_n)
        out_word[WIDTH] |-> ((&out_word[WIDTH-1:0]) || (out_word[WIDTH-1:0] == '0))); // R4

    AST_FILL_HOLD: assert property (@(posedge enc_clk) disable iff (!rst_n)
        full |=> full); // R7

    AST_FMT_LOW_BITS: assert property (@(posedge enc_clk) disable iff (!rst_n)
        fmt_word[WIDTH-2:0] == out_word[WIDTH-2:0]); // R2

    AST_FMT_MSB: assert property (@(posedge enc_clk) disable iff (!rst_n)
        (fmt_word[WIDTH-1] == out_word[WIDTH-1]) == fmt_sel); // R2

endmodule

bind adc_out_stage adc_out_stage_chk #(.WIDTH(WIDTH)) u_chk (
    .enc_clk  (enc_clk),
    .rst_n    (rst_n),
    .over_hi  (over_hi),
    .over_lo  (over_lo),
    .fmt_sel  (fmt_sel),
    .cap_word (cap_word),
    .out_word (out_word),
    .fmt_word (fmt_word),
    .full     (full)
);

// File: tb/adc_out_stage_tb.sv
// Bench for adc_out_stage. Inputs change 15 ns after each rising edge. Data is
// checked 5 ns after the edge and the data-valid clock 15 ns after it. The output
// nets carry pull-ups, so a released output reads all ones.
module adc_out_stage_tb;

    localparam int W   = 14;
    localparam int LAT = 5;

    logic         enc_clk = 1'b0;
    logic         rst_n   = 1'b0;
    logic [W-1:0] code_in = '0;
    logic         over_hi = 1'b0;
    logic         over_lo = 1'b0;
    logic         fmt_sel = 1'b1;
    logic         oe_n    = 1'b0;
    tri1  [W-1:0] dat_bus;
    tri1          ovf_net;
    tri1          dck_net;

    int n_vec = 0;
    int n_bad = 0;
    int fill  = 0;
    logic [W:0] mdl [0:LAT];

    adc_out_stage #(.WIDTH(W), .LATENCY(LAT)) u_dut (
        .enc_clk    (enc_clk),
        .rst_n      (rst_n),
        .code_in    (code_in),
        .over_hi    (over_hi),
        .over_lo    (over_lo),
        .fmt_sel    (fmt_sel),
        .oe_n       (oe_n),
        .dat_out    (dat_bus),
        .ovf_out    (ovf_net),
        .dvalid_clk (dck_net)
    );

    always #10 enc_clk = ~enc_clk;

    // Expected stored word: R3 substitution with the flag in bit 14.
    function automatic logic [W:0] exp_word(logic [W-1:0] c, logic h, logic l);
        if (h)      return {1'b1, {W{1'b1}}};
        else if (l) return {1'b1, {W{1'b0}}};
        else        return {1'b0, c};
    endfunction

    // Expected bus value: R2 format, where 0 inverts bit 13.
    function automatic logic [W-1:0] exp_fmt(logic [W-1:0] c, logic f);
        return f ? c : (c ^ 14'h2000);
    endfunction

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // One encode cycle: apply inputs, take the edge, update the model, check.
    task automatic cycle(input logic r, input logic [W-1:0] c, input logic h,
                         input logic l, input logic f, input logic e);
        rst_n = r; code_in = c; over_hi = h; over_lo = l; fmt_sel = f; oe_n = e;
        @(posedge enc_clk);
        if (!r) begin
            for (int i = 0; i <= LAT; i++) mdl[i] = '0;
            fill = 0;
        end else begin
            for (int i = LAT; i > 0; i--) mdl[i] = mdl[i-1];
            mdl[0] = exp_word(c, h, l);
            if (fill < LAT + 1) fill++;
        end
        #5;
        if (e) begin
            chk(dat_bus == {W{1'b1}}, "R5 data released", 32'(dat_bus), 32'h3fff);
            chk(ovf_net == 1'b1, "R5 flag released", 32'(ovf_net), 32'h1);
            chk(dck_net == 1'b1, "R5 clock released", 32'(dck_net), 32'h1);
        end else begin
            chk(dat_bus == exp_fmt(mdl[LAT][W-1:0], f), "R1/R2/R8 data word",
                32'(dat_bus), 32'(exp_fmt(mdl[LAT][W-1:0], f)));
            chk(ovf_net == mdl[LAT][W], "R4 overflow aligned", 32'(ovf_net), 32'(mdl[LAT][W]));
            chk(dck_net == 1'b0, "R6 clock low in high phase", 32'(dck_net), 32'h0);
        end
        #10;
        if (e) chk(dck_net == 1'b1, "R5 clock released low phase", 32'(dck_net), 32'h1);
        else   chk(dck_net == (fill == LAT + 1), "R6/R7 clock in low phase",
                   32'(dck_net), 32'(fill == LAT + 1));
    endtask

    initial begin
        #4_000_000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic f;
        logic e;
        void'($urandom(32'd20417));
        for (int i = 0; i <= LAT; i++) mdl[i] = '0;
        #15;
        // R7: reset state, both formats.
        cycle(1'b0, 14'h1234, 1'b0, 1'b0, 1'b1, 1'b0);
        cycle(1'b0, 14'h1234, 1'b0, 1'b0, 1'b0, 1'b0);
        // R7/R1: fill the line; clock held low for the first five edges.
        for (int i = 0; i < 8; i++) cycle(1'b1, 14'(16'h0100 + i), 1'b0, 1'b0, 1'b1, 1'b0);
        // R3 with R2: over-range, under-range and both, in two's complement.
        cycle(1'b1, 14'h0555, 1'b1, 1'b0, 1'b0, 1'b0);
        cycle(1'b1, 14'h2aaa, 1'b0, 1'b1, 1'b0, 1'b0);
        cycle(1'b1, 14'h1111, 1'b1, 1'b1, 1'b0, 1'b0);
        cycle(1'b1, 14'h3fff, 1'b0, 1'b0, 1'b0, 1'b0);
        cycle(1'b1, 14'h0000, 1'b0, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 6; i++) cycle(1'b1, 14'h2000, 1'b0, 1'b0, 1'b0, 1'b0);
        // Random run with released windows (R5, R8) and a mid-run reset (R7).
        f = 1'b1;
        for (int i = 0; i < 400; i++) begin
            if (i % 32 == 0) f = 1'($urandom);
            e = (i >= 60 && i < 72) || (i >= 150 && i < 153);
            cycle((i < 220 || i > 222), 14'($urandom),
                  ($urandom % 8) == 0, ($urandom % 8) == 0, f, e);
        end
        // Release on the edge where the line refills after a reset.
        cycle(1'b0, 14'h0abc, 1'b0, 1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 8; i++) cycle(1'b1, 14'(16'h3000 + i), 1'b0, 1'b0, 1'b1, (i == 5));
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule